// File: doc/BRIEF.md
# YCbCr Video Capture with Nested Crop Window

The block takes an 8-bit interleaved luma/chroma byte stream that arrives on a pixel clock, with separate horizontal and vertical sync wires. The two bytes of each pixel come as luma then chroma, and the chroma alternates between Cb and Cr from pixel to pixel (Y0 Cb0 Y1 Cr0 Y2 Cb1 ...). Each input can be captured on the rising or the falling edge of the pixel clock, and each sync wire has its own active level. The block counts bytes from the start of each horizontal sync and lines from the start of each vertical sync. It then forwards only the bytes that fall inside a processing sub-window.

Two crops are nested. The outer crop is the valid image area. It has a start offset after horizontal sync and a width, both in pixel units of two bytes, plus a height in lines. The inner crop is the processing sub-window inside that area. It has its own horizontal start and width, also in pixel units and measured from the image start, and its own first line and line count. A byte leaves the block only if it lies in both crops. The output carries a valid strobe, a start-of-line flag on the first byte of each sub-window line, and a start-of-frame flag on the first byte of the first sub-window line. All crop settings are taken at the start of vertical sync, so a change during a frame does not affect that frame.

Top module: `yc_crop_window`

## Requirements
- R1: While `rst` is high, and on the first output cycle after it falls, `vout_valid`, `vout_sol` and `vout_sof` are 0.
- R2: When `edge_fall` is 0, the data and both syncs are captured on the rising edge of `pclk`. When it is 1, they are captured on the falling edge. A value present only around the other edge has no effect on the output.
- R3: `hs_act_high` = 0 makes `vin_hs` active low, and 1 makes it active high. The byte captured in the first cycle of active horizontal sync is byte 0 of the line.
- R4: `vs_act_high` = 0 makes `vin_vs` active low, and 1 makes it active high. The first horizontal sync start after a vertical sync start begins image line 0. If both syncs start in the same capture, that capture only begins the frame.
- R5: On an image line, the sub-window passes bytes 2*(`cfg_img_xst`+`cfg_win_xst`) up to, but not including, 2*(`cfg_img_xst`+`cfg_win_xst`+`cfg_win_xsize`), in input order and with each data value unchanged.
- R6: Bytes outside the image area are never passed. That area runs from byte 2*`cfg_img_xst` and is 2*`cfg_img_xsize` bytes long. A sub-window that reaches past it is cut at the image edge.
- R7: Only lines `cfg_win_yst` to `cfg_win_yst`+`cfg_win_ysize`-1 that are also below `cfg_img_ysize` produce output. A line count of 0 produces no output.
- R8: `vout_sol` is 1 exactly on the first passed byte of each sub-window line. `vout_sof` is 1 only on the first passed byte of line `cfg_win_yst`, which is at most once per frame, and is always paired with `vout_sol`.
- R9: All seven crop inputs are sampled in the capture where vertical sync becomes active. Changes at any other time take effect from the next frame.
- R10: `vout_sol` and `vout_sof` are 1 only together with `vout_valid`. `vout_data` is 0 when `vout_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_fall | input | 1 | 0 captures on the rising edge, 1 on the falling edge |
| hs_act_high | input | 1 | Horizontal sync level: 1 is active high, 0 is active low |
| vs_act_high | input | 1 | Vertical sync level: 1 is active high, 0 is active low |
| cfg_img_xst | input | 12 | Image start after horizontal sync, in pixels |
| cfg_img_xsize | input | 12 | Image width, in pixels |
| cfg_win_xst | input | 12 | Sub-window start inside the image, in pixels |
| cfg_win_xsize | input | 12 | Sub-window width, in pixels |
| cfg_img_ysize | input | 12 | Image height, in lines |
| cfg_win_yst | input | 12 | First sub-window line |
| cfg_win_ysize | input | 12 | Sub-window height, in lines |
| vin_data | input | 8 | Input byte |
| vin_hs | input | 1 | Horizontal sync |
| vin_vs | input | 1 | Vertical sync |
| vout_data | output | 8 | Passed byte, 0 when not valid |
| vout_valid | output | 1 | Byte is inside the sub-window |
| vout_sol | output | 1 | First byte of a sub-window line |
| vout_sof | output | 1 | First byte of a frame's sub-window |

## Verification
With rising capture, a byte taken on a rising edge appears on the outputs after the next rising edge. With falling capture, a byte taken on a falling edge is moved into the rising-edge stage at the next rising edge and appears one rising edge after that. The bench writes the correct value only into the half cycle that contains the selected edge and an inverted value into the other half, so sampling on the wrong edge corrupts data and syncs. Because the delay differs by mode, the expected bytes wait in an ordered queue and are compared as they come out, with outputs sampled on the falling edge in both modes. After each frame the bench waits a few cycles, then checks that every expected byte has arrived and no extra ones have.

// File: rtl/yc_crop_pkg.sv
package yc_crop_pkg;

    localparam int YC_DW = 8;            // byte width
    localparam int YC_CW = 12;           // counter / config field width
    localparam int YC_SW = YC_CW + 3;    // headroom for byte-unit sums

    typedef struct packed {
        logic [YC_CW-1:0] img_xst;
        logic [YC_CW-1:0] img_xsize;
        logic [YC_CW-1:0] win_xst;
        logic [YC_CW-1:0] win_xsize;
        logic [YC_CW-1:0] img_ysize;
        logic [YC_CW-1:0] win_yst;
        logic [YC_CW-1:0] win_ysize;
    } crop_cfg_t;

    // one captured byte with syncs normalised to active-high
    typedef struct packed {
        logic [YC_DW-1:0] data;
        logic             hs;
        logic             vs;
    } yc_smp_t;

    function automatic logic in_span(input logic [YC_SW-1:0] v,
                                     input logic [YC_SW-1:0] lo,
                                     input logic [YC_SW-1:0] len);
        return (v >= lo) && (v < lo + len);
    endfunction

    function automatic logic [YC_SW-1:0] pix2byte(input logic [YC_CW-1:0] p);
        return YC_SW'({p, 1'b0});
    endfunction

    function automatic logic [YC_CW-1:0] sat_inc(input logic [YC_CW-1:0] x);
        return (x == '1) ? x : x + 1'b1;
    endfunction

endpackage

// File: rtl/yc_edge_sampler.sv
module yc_edge_sampler
    import yc_crop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_fall,
    input  logic             hs_act_high,
    input  logic             vs_act_high,
    input  logic [YC_DW-1:0] din,
    input  logic             hs_raw,
    input  logic             vs_raw,
    output yc_smp_t          smp
);

    yc_smp_t live;
    yc_smp_t fall_q;

    always_comb begin
        live.data = din;
        live.hs   = hs_act_high ? hs_raw : ~hs_raw;
        live.vs   = vs_act_high ? vs_raw : ~vs_raw;
    end

    // falling-edge capture, handed to the rising domain half a cycle later
    always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= live;
    end

    always_ff @(posedge clk) begin
        if (rst)            smp <= '0;
        else if (edge_fall) smp <= fall_q;
        else                smp <= live;
    end

endmodule

// File: rtl/yc_line_tracker.sv
module yc_line_tracker
    import yc_crop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  yc_smp_t          smp,
    input  crop_cfg_t        cfg_in,
    output logic [YC_CW-1:0] byte_idx,
    output logic [YC_CW-1:0] line_num,   // 0 = before first line, 1 = image line 0
    output crop_cfg_t        cfg_act,
    output logic             frame_edge
);

    logic             hs_prev, vs_prev;
    logic [YC_CW-1:0] byte_q, line_q;
    crop_cfg_t        shadow;
    logic             line_edge;

    assign line_edge  = smp.hs & ~hs_prev;
    assign frame_edge = smp.vs & ~vs_prev;

    always_comb begin
        byte_idx = line_edge ? '0 : sat_inc(byte_q);
        if (frame_edge)     line_num = '0;
        else if (line_edge) line_num = sat_inc(line_q);
        else                line_num = line_q;
        cfg_act  = frame_edge ? cfg_in : shadow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_prev <= 1'b0;
            vs_prev <= 1'b0;
            byte_q  <= '1;
            line_q  <= '0;
            shadow  <= '0;
        end else begin
            hs_prev <= smp.hs;
            vs_prev <= smp.vs;
            byte_q  <= byte_idx;
            line_q  <= line_num;
            shadow  <= cfg_act;
        end
    end

endmodule

// File: rtl/yc_window_gate.sv
module yc_window_gate
    import yc_crop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [YC_DW-1:0] data,
    input  logic [YC_CW-1:0] byte_idx,
    input  logic [YC_CW-1:0] line_num,
    input  crop_cfg_t        cfg,
    output logic [YC_DW-1:0] q_data,
    output logic             q_valid,
    output logic             q_sol,
    output logic             q_sof
);

    logic [YC_SW-1:0] b, img_lo, win_lo, li;
    logic [YC_CW-1:0] line_ix;
    logic             h_ok, v_ok, hit, first, frame_first;

    always_comb begin
        b       = YC_SW'(byte_idx);
        img_lo  = pix2byte(cfg.img_xst);
        win_lo  = img_lo + pix2byte(cfg.win_xst);
        h_ok    = in_span(b, img_lo, pix2byte(cfg.img_xsize)) &&
                  in_span(b, win_lo, pix2byte(cfg.win_xsize));
        line_ix = line_num - 1'b1;
        li      = YC_SW'(line_ix);
        v_ok    = (line_num != '0) && (line_ix < cfg.img_ysize) &&
                  in_span(li, YC_SW'(cfg.win_yst), YC_SW'(cfg.win_ysize));
        hit         = h_ok && v_ok;
        first       = hit && (b == win_lo);
        frame_first = first && (line_ix == cfg.win_yst);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_data  <= '0;
            q_valid <= 1'b0;
            q_sol   <= 1'b0;
            q_sof   <= 1'b0;
        end else begin
            q_data  <= hit ? data : '0;
            q_valid <= hit;
            q_sol   <= first;
            q_sof   <= frame_first;
        end
    end

endmodule

// File: rtl/yc_crop_window.sv
module yc_crop_window
    import yc_crop_pkg::*;
#(
    parameter int DW = YC_DW,
    parameter int CW = YC_CW
) (
    input  logic          pclk,
    input  logic          rst,
    input  logic          edge_fall,
    input  logic          hs_act_high,
    input  logic          vs_act_high,
    input  logic [CW-1:0] cfg_img_xst,
    input  logic [CW-1:0] cfg_img_xsize,
    input  logic [CW-1:0] cfg_win_xst,
    input  logic [CW-1:0] cfg_win_xsize,
    input  logic [CW-1:0] cfg_img_ysize,
    input  logic [CW-1:0] cfg_win_yst,
    input  logic [CW-1:0] cfg_win_ysize,
    input  logic [DW-1:0] vin_data,
    input  logic          vin_hs,
    input  logic          vin_vs,
    output logic [DW-1:0] vout_data,
    output logic          vout_valid,
    output logic          vout_sol,
    output logic          vout_sof
);

    crop_cfg_t        cfg_in, cfg_act;
    yc_smp_t          smp;
    logic [YC_CW-1:0] byte_idx, line_num;
    logic             frame_edge;

    always_comb begin
        cfg_in.img_xst   = cfg_img_xst;
        cfg_in.img_xsize = cfg_img_xsize;
        cfg_in.win_xst   = cfg_win_xst;
        cfg_in.win_xsize = cfg_win_xsize;
        cfg_in.img_ysize = cfg_img_ysize;
        cfg_in.win_yst   = cfg_win_yst;
        cfg_in.win_ysize = cfg_win_ysize;
    end

    yc_edge_sampler u_smp (
        .clk(pclk), .rst(rst), .edge_fall(edge_fall),
        .hs_act_high(hs_act_high), .vs_act_high(vs_act_high),
        .din(vin_data), .hs_raw(vin_hs), .vs_raw(vin_vs), .smp(smp)
    );

    yc_line_tracker u_trk (
        .clk(pclk), .rst(rst), .smp(smp), .cfg_in(cfg_in),
        .byte_idx(byte_idx), .line_num(line_num),
        .cfg_act(cfg_act), .frame_edge(frame_edge)
    );

    yc_window_gate u_gate (
        .clk(pclk), .rst(rst), .data(smp.data),
        .byte_idx(byte_idx), .line_num(line_num), .cfg(cfg_act),
        .q_data(vout_data), .q_valid(vout_valid),
        .q_sol(vout_sol), .q_sof(vout_sof)
    );

endmodule

// File: rtl/yc_crop_window_chk.sv
module yc_crop_window_chk (
    input logic clk,
    input logic rst,
    input logic valid,
    input logic sol,
    input logic sof,
    input logic frame_edge
);

    logic sof_seen;

    always_ff @(posedge clk) begin
        if (rst)             sof_seen <= 1'b0;
        else if (frame_edge) sof_seen <= 1'b0;
        else if (sof)        sof_seen <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!valid && !sol && !sof));

    // R10
    flag_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (sol || sof) |-> valid);

    // R8
    sof_with_sol_chk: assert property (@(posedge clk) disable iff (rst)
        sof |-> sol);

    // R5
    burst_opens_sol_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> sol);

    // R8
    single_sof_chk: assert property (@(posedge clk) disable iff (rst)
        sof |-> !sof_seen);

endmodule

bind yc_crop_window yc_crop_window_chk u_chk (
    .clk(pclk), .rst(rst), .valid(vout_valid), .sol(vout_sol),
    .sof(vout_sof), .frame_edge(frame_edge)
);

// File: tb/sim_yc_crop_window.sv
`timescale 1ns/1ps
module sim_yc_crop_window;

    typedef struct packed {
        logic [7:0] d;
        logic       sol;
        logic       sof;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        edge_fall = 1'b0, hs_hi = 1'b0, vs_hi = 1'b0;
    logic [11:0] c_ixst = '0, c_ixsz = '0, c_wxst = '0, c_wxsz = '0;
    logic [11:0] c_iysz = '0, c_wyst = '0, c_wysz = '0;
    logic [7:0]  vin_data = '0;
    logic        vin_hs = 1'b1, vin_vs = 1'b1;
    logic [7:0]  vout_data;
    logic        vout_valid, vout_sol, vout_sof;

    int   n_chk = 0, n_bad = 0, pushed = 0, popped = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    yc_crop_window u0 (
        .pclk(clk), .rst(rst), .edge_fall(edge_fall),
        .hs_act_high(hs_hi), .vs_act_high(vs_hi),
        .cfg_img_xst(c_ixst), .cfg_img_xsize(c_ixsz),
        .cfg_win_xst(c_wxst), .cfg_win_xsize(c_wxsz),
        .cfg_img_ysize(c_iysz), .cfg_win_yst(c_wyst), .cfg_win_ysize(c_wysz),
        .vin_data(vin_data), .vin_hs(vin_hs), .vin_vs(vin_vs),
        .vout_data(vout_data), .vout_valid(vout_valid),
        .vout_sol(vout_sol), .vout_sof(vout_sof)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // correct value only in the half cycle holding the selected edge
    task automatic drive_slot(input logic [7:0] d, input logic h, input logic v);
        logic ph, pv;
        ph = hs_hi ? h : ~h;
        pv = vs_hi ? v : ~v;
        @(posedge clk); #1;
        if (edge_fall) begin vin_data = d;  vin_hs = ph;  vin_vs = pv;  end
        else           begin vin_data = ~d; vin_hs = ~ph; vin_vs = ~pv; end
        @(negedge clk); #1;
        if (edge_fall) begin vin_data = ~d; vin_hs = ~ph; vin_vs = ~pv; end
        else           begin vin_data = d;  vin_hs = ph;  vin_vs = pv;  end
    endtask

    task automatic frame(input string tag, input bit fall, input bit hp, input bit vp,
                         input int ixst, input int ixsz, input int wxst, input int wxsz,
                         input int iysz, input int wyst, input int wysz,
                         input int lines, input int llen, input bit chg, input int seed);
        int wlo, whi, ilo, ihi;
        edge_fall = fall; hs_hi = hp; vs_hi = vp;
        c_ixst = 12'(ixst); c_ixsz = 12'(ixsz); c_wxst = 12'(wxst); c_wxsz = 12'(wxsz);
        c_iysz = 12'(iysz); c_wyst = 12'(wyst); c_wysz = 12'(wysz);
        ilo = 2 * ixst; ihi = 2 * (ixst + ixsz);
        wlo = 2 * (ixst + wxst); whi = 2 * (ixst + wxst + wxsz);
        for (int i = 0; i < 8; i++) drive_slot(8'h00, 1'b0, (i >= 2 && i < 5));
        for (int j = 0; j < lines; j++) begin
            for (int b = 0; b < llen; b++) begin
                logic [7:0] d;
                d = 8'((j * 37 + b * 5 + seed) & 8'hFF);
                if (chg && j == 1 && b == 0) begin
                    c_ixst = '0; c_ixsz = 12'd20; c_wxst = '0; c_wxsz = 12'd20;
                    c_iysz = 12'd20; c_wyst = '0; c_wysz = 12'd20;
                end
                if (j < iysz && j >= wyst && j < wyst + wysz &&
                    b >= ilo && b < ihi && b >= wlo && b < whi) begin
                    q.push_back('{d: d, sol: (b == wlo), sof: (b == wlo && j == wyst)});
                    pushed++;
                end
                drive_slot(d, (b < 4), 1'b0);
            end
        end
        for (int i = 0; i < 6; i++) drive_slot(8'h00, 1'b0, 1'b0);
        check(popped == pushed, tag, popped, pushed);
    endtask

    // monitor: outputs sampled on the falling edge, compared in order
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                check(!vout_valid && !vout_sol && !vout_sof && vout_data == 8'h00,
                      "R1 reset outputs", {vout_valid, vout_sol, vout_sof}, 0);
            end else if (vout_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R5/R6/R7 unexpected byte", vout_data, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    popped++;
                    check({vout_data, vout_sol, vout_sof} == e,
                          "R2/R3/R4/R5/R8 byte+flags", {vout_data, vout_sol, vout_sof}, e);
                end
            end else begin
                check(!vout_sol && !vout_sof && vout_data == 8'h00,
                      "R10 idle outputs", {vout_data, vout_sol, vout_sof}, 0);
            end
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            summary();
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        // R2 R3 R4 R5: rising capture, active-low syncs
        frame("R5 frame count", 1'b0, 1'b0, 1'b0, 3, 10, 2, 4, 5, 1, 3, 7, 40, 1'b0, 11);
        // R6 R7: falling capture, active-high syncs, window clipped both ways
        frame("R6/R7 clipped count", 1'b1, 1'b1, 1'b1, 2, 6, 3, 8, 3, 1, 5, 6, 30, 1'b0, 50);
        // R9: mid-frame config change ignored; window at byte 0, line 0
        frame("R9 mid-frame change count", 1'b0, 1'b1, 1'b0, 0, 3, 0, 3, 4, 0, 4, 5, 20, 1'b1, 90);
        // R9: new config used on the next frame
        frame("R9 next-frame config count", 1'b1, 1'b0, 1'b1, 5, 4, 1, 2, 8, 6, 2, 9, 24, 1'b0, 130);
        // R7: zero-height window emits nothing
        frame("R7 zero lines count", 1'b0, 1'b0, 1'b0, 1, 4, 0, 4, 4, 0, 0, 3, 16, 1'b0, 170);
        check(q.size() == 0, "R5 queue drained", q.size(), 0);
        finished = 1'b1;
        summary();
    end

endmodule